// File: doc/BRIEF.md
# USB Receive Bit-Unstuffing and Stuff-Error Checker

This block sits on the receive path of a full-speed or low-speed USB link, after NRZI decoding and clock recovery. It takes one decoded line bit on each bit strobe, together with single-cycle packet-start and packet-end markers. It removes the zero that the transmitter inserts after every run of six ones. It also watches for runs of ones that break the stuffing rule. Because it advances only on the strobe, the same logic serves the 12 Mbps and 1.5 Mbps rates.

Data bits leave the block one cycle after their strobe, each with a valid pulse. Stuffed zeros are never forwarded. If a one arrives where a stuffed zero was due, the block sets a packet error flag. The flag stays set until the next packet starts, so downstream logic can discard the packet. When the packet-end marker arrives, the block pulses a done signal, and the error flag is final in that same cycle. A run of exactly six ones that ends right at packet end is accepted. This covers the case where hub skew stretches the last bit into an extra one.

Top module: `usb_unstuff_chk`

## Requirements
- R1: While reset is held and in the first cycle after it, `data_vld`, `data_out`, `pkt_done` and `pkt_err` are all 0.
- R2: Inside an open packet, a bit strobed with `bit_stb` that is not in a stuff slot appears on `data_out`, with `data_vld` high, in the cycle after the strobe.
- R3: After six consecutive ones, a strobed zero is a stuffed bit. It is removed: `data_vld` stays low in the following cycle and `pkt_err` is unchanged.
- R4: After six consecutive ones, a strobed one is a stuffing violation. `pkt_err` goes high in the cycle after it and the bit is not forwarded. The run counter then restarts from zero.
- R5: The run counter clears on every forwarded zero and on `pkt_start`. So five ones, a zero and five ones are all forwarded. A run cut short by a new packet start does not carry into the new packet.
- R6: Six consecutive ones followed directly by `pkt_end` are accepted: `pkt_err` stays 0.
- R7: `pkt_done` is high for exactly one cycle, the cycle after `pkt_end` is seen inside an open packet. In that cycle `pkt_err` shows whether the packet broke the stuffing rule.
- R8: `pkt_err`, once set, stays set through packet end until the cycle after the next `pkt_start`, where it reads 0.
- R9: Strobed bits and `pkt_end` outside an open packet are ignored. No `data_vld`, no `pkt_done`, and `pkt_err` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | Single-cycle pulse opening a packet; never in the same cycle as a strobe or `pkt_end` |
| pkt_end | input | 1 | Single-cycle pulse closing the packet after its last bit |
| bit_stb | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Decoded line bit |
| data_out | output | 1 | Unstuffed data bit |
| data_vld | output | 1 | `data_out` holds a data bit this cycle |
| pkt_done | output | 1 | One-cycle pulse after packet end |
| pkt_err | output | 1 | Sticky stuffing-violation flag for the current packet |

## Verification
A run counter that drifts shows up at the ports within one strobe. If it counts high, a genuine data bit is dropped and `data_vld` is missing in the cycle after that bit. If it counts low, a stuffed zero leaks through as a valid bit, or a seventh one slips past without raising `pkt_err`. If the counter is not cleared at packet start, the first zero of the next packet is dropped. A stuck packet-open flag shows as bits forwarded outside packets, or as a missing `pkt_done` one cycle after `pkt_end`.

// File: rtl/usb_unstuff_pkg.sv
// Package: shared constants and types for the bit-unstuffing checker.
// Assumes: the stuffing rule inserts one zero after a fixed run of ones.
package usb_unstuff_pkg;

    // Run of ones after which a stuffed zero is due on the USB line.
    localparam int DEF_RUN_LEN = 6;

    // What to do with the bit arriving on the current strobe.
    typedef enum logic [1:0] {
        SLOT_DATA = 2'd0,   // ordinary data bit, forward it
        SLOT_DROP = 2'd1,   // stuffed zero, consume it
        SLOT_VIOL = 2'd2    // one where a stuffed zero was due
    } slot_kind_t;

endpackage

// File: rtl/usb_run_counter.sv
// Module: usb_run_counter
// Counts consecutive ones among the accepted bits of a packet and classifies
// each incoming bit as data, stuffed zero or stuffing violation.
// Assumes: clr and adv are never high in the same cycle; adv only inside a packet.
module usb_run_counter
    import usb_unstuff_pkg::*;
#(
    parameter int RUN_LEN = DEF_RUN_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic       bit_in,
    output slot_kind_t kind
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_q;
    logic             slot_due;

    assign slot_due = (run_q == RUN_MAX);

    // Classify the current bit from the run length seen so far.
    always_comb begin
        if (!slot_due)   kind = SLOT_DATA;
        else if (bit_in) kind = SLOT_VIOL;
        else             kind = SLOT_DROP;
    end

    // Track the run of ones; restart on zero, on the stuff slot and at packet start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (adv) begin
            if (slot_due || !bit_in) run_q <= '0;
            else                     run_q <= run_q + 1'b1;
        end
    end

    // R5: the run never grows past the stuff slot
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

    // R5: a packet start always restarts the run
    run_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (run_q == '0));

endmodule

// File: rtl/usb_pkt_tracker.sv
// Module: usb_pkt_tracker
// Holds the packet-open state and the sticky error flag, and issues the
// packet-done pulse one cycle after the end marker.
// Assumes: start, end and violation markers are single-cycle and never coincide.
module usb_pkt_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic end_i,
    input  logic viol_i,
    output logic open_o,
    output logic err_o,
    output logic done_o
);
    // Packet-open flag: set by start, cleared by end.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_o <= 1'b0;
        else if (start_i) open_o <= 1'b1;
        else if (end_i)   open_o <= 1'b0;
    end

    // Sticky error: cleared at packet start, set by any violation.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_o <= 1'b0;
        else if (start_i) err_o <= 1'b0;
        else if (viol_i)  err_o <= 1'b1;
    end

    // Done pulse for an end marker that closes an open packet.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= end_i && open_o;
    end

    // R4: a violation raises the error flag on the next cycle
    viol_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_i |=> err_o);

    // R8: the error flag holds until a packet start
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

    // R8: a packet start clears the error flag
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !err_o);

    // R7: the done pulse lasts a single cycle
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/usb_unstuff_chk.sv
// Module: usb_unstuff_chk (top)
// Removes stuffed zeros from a decoded USB full/low-speed bit stream and
// flags stuffing violations per packet. Advances on a bit strobe only.
// Assumes: pkt_start never shares a cycle with bit_stb or pkt_end.
module usb_unstuff_chk
    import usb_unstuff_pkg::*;
#(
    parameter int RUN_LEN = DEF_RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_start,
    input  logic pkt_end,
    input  logic bit_stb,
    input  logic bit_in,
    output logic data_out,
    output logic data_vld,
    output logic pkt_done,
    output logic pkt_err
);
    logic       pkt_open;
    logic       adv;
    logic       viol;
    slot_kind_t kind;

    assign adv  = bit_stb && pkt_open;
    assign viol = adv && (kind == SLOT_VIOL);

    usb_run_counter #(.RUN_LEN(RUN_LEN)) run_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pkt_start),
        .adv    (adv),
        .bit_in (bit_in),
        .kind   (kind)
    );

    usb_pkt_tracker trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pkt_start),
        .end_i   (pkt_end),
        .viol_i  (viol),
        .open_o  (pkt_open),
        .err_o   (pkt_err),
        .done_o  (pkt_done)
    );

    // Register forwarded data bits one cycle after their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_vld <= 1'b0;
            data_out <= 1'b0;
        end else begin
            data_vld <= adv && (kind == SLOT_DATA);
            data_out <= (adv && (kind == SLOT_DATA)) ? bit_in : 1'b0;
        end
    end

    // R9: a valid data bit always stems from a strobe in the previous cycle
    vld_from_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |-> $past(bit_stb));

    // R7: the done pulse follows an end marker
    done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(pkt_end));

    // R3: output data is never reported without its valid
    data_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_out |-> data_vld);

endmodule

// File: tb/usb_unstuff_chk_tb_top.sv
// Bench: directed scenarios for usb_unstuff_chk, one task per scenario.
module usb_unstuff_chk_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_start = 1'b0, pkt_end = 1'b0, bit_stb = 1'b0, bit_in = 1'b0;
    logic data_out, data_vld, pkt_done, pkt_err;
    int   checks = 0;
    int   failures = 0;
    logic fin = 1'b0;

    always #2 clk = ~clk;

    usb_unstuff_chk dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .bit_stb(bit_stb), .bit_in(bit_in), .data_out(data_out),
        .data_vld(data_vld), .pkt_done(pkt_done), .pkt_err(pkt_err)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, sample after the next rising edge.
    task automatic step(input logic s, input logic e, input logic stb, input logic b);
        @(negedge clk);
        pkt_start = s; pkt_end = e; bit_stb = stb; bit_in = b;
        @(posedge clk);
        #1;
        pkt_start = 1'b0; pkt_end = 1'b0; bit_stb = 1'b0; bit_in = 1'b0;
    endtask

    task automatic send(input logic b, input logic exp_vld, input string tag);
        step(1'b0, 1'b0, 1'b1, b);
        chk(data_vld, exp_vld, {tag, " data_vld"});
        if (exp_vld) chk(data_out, b, {tag, " data_out"});
    endtask

    task automatic start_pkt();
        step(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic end_pkt(input logic exp_err, input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk(pkt_done, 1'b1, {tag, " R7 pkt_done"});
        chk(pkt_err, exp_err, {tag, " pkt_err at done"});
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(pkt_done, 1'b0, {tag, " R7 done single cycle"});
    endtask

    task automatic t_reset();
        chk(data_vld, 1'b0, "R1 data_vld");
        chk(data_out, 1'b0, "R1 data_out");
        chk(pkt_done, 1'b0, "R1 pkt_done");
        chk(pkt_err, 1'b0, "R1 pkt_err");
    endtask

    task automatic t_plain();
        start_pkt();
        send(1'b1, 1'b1, "R2 b0"); send(1'b0, 1'b1, "R2 b1");
        send(1'b1, 1'b1, "R2 b2"); send(1'b1, 1'b1, "R2 b3");
        send(1'b0, 1'b1, "R2 b4");
        end_pkt(1'b0, "R2 plain");
    endtask

    task automatic t_stuff();
        start_pkt();
        for (int i = 0; i < 6; i++) send(1'b1, 1'b1, "R3 run");
        send(1'b0, 1'b0, "R3 stuffed zero dropped");
        chk(pkt_err, 1'b0, "R3 no error");
        send(1'b1, 1'b1, "R3 after stuff");
        end_pkt(1'b0, "R3 stuff");
    endtask

    task automatic t_zero_clears();
        start_pkt();
        for (int i = 0; i < 5; i++) send(1'b1, 1'b1, "R5 first run");
        send(1'b0, 1'b1, "R5 zero");
        for (int i = 0; i < 5; i++) send(1'b1, 1'b1, "R5 second run");
        send(1'b0, 1'b1, "R5 zero not stuffed");
        end_pkt(1'b0, "R5 zero clears");
        start_pkt();
        for (int i = 0; i < 5; i++) send(1'b1, 1'b1, "R5 cut run");
        start_pkt();
        send(1'b1, 1'b1, "R5 new pkt one");
        send(1'b0, 1'b1, "R5 start cleared run");
        end_pkt(1'b0, "R5 start clears");
    endtask

    task automatic t_violation();
        start_pkt();
        for (int i = 0; i < 6; i++) send(1'b1, 1'b1, "R4 run");
        send(1'b1, 1'b0, "R4 seventh one dropped");
        chk(pkt_err, 1'b1, "R4 error raised");
        send(1'b1, 1'b1, "R4 run restarted");
        send(1'b0, 1'b1, "R4 zero after");
        chk(pkt_err, 1'b1, "R8 error held");
        end_pkt(1'b1, "R4 violation");
        chk(pkt_err, 1'b1, "R8 error held after done");
        start_pkt();
        chk(pkt_err, 1'b0, "R8 start clears error");
        end_pkt(1'b0, "R8 empty");
    endtask

    task automatic t_dribble();
        start_pkt();
        send(1'b0, 1'b1, "R6 lead");
        for (int i = 0; i < 6; i++) send(1'b1, 1'b1, "R6 run");
        end_pkt(1'b0, "R6 dribble");
    endtask

    task automatic t_outside();
        for (int i = 0; i < 8; i++) send(1'b1, 1'b0, "R9 bit outside");
        chk(pkt_err, 1'b0, "R9 no error outside");
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk(pkt_done, 1'b0, "R9 stray end");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_plain();
        t_stuff();
        t_zero_clears();
        t_violation();
        t_dribble();
        t_outside();
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule